// File: doc/BRIEF.md
# Triple Programmable Interval Timer

Three independent 16-bit down-counters share one byte-wide host port. Each channel has a count-enable input (`tick`), a gate input and a single output. A control word selects the channel's mode and whether it counts in plain binary or in packed decimal (four digits, 0 to 9999). The 16-bit initial count is written as two bytes. The count can be read at any time, either live or through a snapshot command that freezes a copy while counting continues.

Three modes are supported. The periodic pulse mode drives the output low for one tick in every N ticks and reloads by itself, so it can serve as a baud-rate clock. The half-period mode produces a square wave. The gate-started single pulse mode drives the output low for N ticks after a rising gate edge, and a new edge restarts the pulse. Everything is synchronous to one system clock. A channel advances only in cycles where its `tick` is high.

Host map: `addr` 0..2 selects a channel's count register, and `addr` 3 is the control register. A control word has these fields:
- bits [7:6] channel;
- bit 5 snapshot command;
- bits [4:3] reserved, must be 0;
- bits [2:1] mode: 00 single pulse, 01 periodic pulse, 1x square wave;
- bit 0 decimal.

Top module: `ptmr_triple`

## Requirements
- R1: After reset every output is high, and each channel's count reads back as 0x00 then 0x00.
- R2: A count is written low byte first, then high byte, to the channel's address. A channel whose high byte has not yet been written since its last mode write does not count, and its output stays high.
- R3: In periodic pulse mode (mode 01) with gate high, the first tick after the count is loaded sets the counter to N with the output high. The output is low for exactly the one tick period in which the counter holds 1. The next tick reloads N with the output high, giving a period of N ticks.
- R4: In square wave mode (mode 1x) with gate high, the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, starting high on the loading tick.
- R5: In single pulse mode (mode 00), the output stays high until a rising gate edge. The next tick then loads N and drives the output low. The output returns high on the tick that brings the count to 0, so it is low for N ticks. A rising edge during the pulse makes the next tick reload N.
- R6: In periodic or square wave mode, a low gate holds the count and forces the output high. A later rising gate edge makes the next tick reload N.
- R7: With bit 0 of the mode word set, each 4-bit digit counts down 9..0 with a borrow into the next digit, so 0x1000 is followed by 0x0999. A loaded count of 0 acts as the largest count: it is followed by 0xFFFF in binary and 0x9999 in decimal.
- R8: A snapshot command (bit 5 set, bits [7:6] the channel) copies the count. Reads return the copy low byte then high byte while counting goes on. The copy is released only after its high byte is read. Snapshot commands issued while a copy is held are ignored.
- R9: Without a snapshot, reads return the live count, low byte first, then high byte.
- R10: A mode write stops the channel and sets its output high. Control words with channel 3 or non-zero reserved bits change nothing, and reads at the control address return 0.
- R11: Ticks, gates and writes for one channel leave the other channels' counts and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe, one cycle per byte |
| addr | input | 2 | 0..2 channel count register, 3 control register |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid in the cycle `rd_en` is high |
| tick | input | 3 | Per-channel count enable |
| gate | input | 3 | Per-channel gate/trigger |
| out | output | 3 | Per-channel timer output |

## Verification
A corrupted count shows up as an output edge landing one or more ticks early or late. It also shows up as a wrong byte on the next live or snapshot read, which is visible within one read pair. A wrong host byte pointer swaps the low and high bytes at the very next read or count write. A stuck snapshot flag freezes later reads at a stale value, and this is exposed on the read that follows the high-byte read. Decimal borrow errors produce non-decimal digits such as 0x0FFF, which the bench catches right after the 0x1000 boundary and after a zero load.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int CNT_W = 16;
  localparam int DIG_N = CNT_W / 4;

  typedef enum logic [1:0] {
    MD_PULSE1 = 2'b00,
    MD_RATE   = 2'b01,
    MD_SQ     = 2'b10,
    MD_SQ_ALT = 2'b11
  } mode_e;

  typedef struct packed {
    logic [1:0]       mode;
    logic             bcd;
    logic [CNT_W-1:0] reload;
    logic [7:0]       lo;
    logic             wr_hi;
    logic             rd_hi;
    logic             held;
    logic [CNT_W-1:0] snap;
    logic [CNT_W-1:0] cnt;
    logic             out;
    logic             armed;
    logic             load;
    logic             trig;
    logic             run;
    logic             extra;
    logic             gate_q;
  } chan_state_t;

  // Subtract step (1 or 2) in binary or digit-wise decimal.
  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] v,
                                                  input logic [1:0] step,
                                                  input logic bcd);
    logic [CNT_W-1:0] r;
    logic [3:0] dig;
    logic [3:0] sub;
    logic br;
    r = '0;
    br = 1'b0;
    if (!bcd) begin
      r = v - CNT_W'(step);
    end else begin
      for (int d = 0; d < DIG_N; d++) begin
        dig = v[d*4 +: 4];
        sub = (d == 0) ? {2'b00, step} : {3'b000, br};
        if (dig < sub) begin
          r[d*4 +: 4] = dig + 4'd10 - sub;
          br = 1'b1;
        end else begin
          r[d*4 +: 4] = dig - sub;
          br = 1'b0;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ptmr_step.sv
module ptmr_step
  import ptmr_pkg::*;
(
  input  logic [CNT_W-1:0] value,
  input  logic             bcd,
  output logic [CNT_W-1:0] minus1,
  output logic [CNT_W-1:0] minus2
);
  always_comb begin
    minus1 = count_down(value, 2'd1, bcd);
    minus2 = count_down(value, 2'd2, bcd);
  end
endmodule

// File: rtl/ptmr_chan.sv
module ptmr_chan
  import ptmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       gate,
  input  logic       cfg_we,
  input  logic       cfg_snap,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_bcd,
  input  logic       data_we,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  output logic [7:0] rd_byte,
  output logic       out_o
);
  chan_state_t st_q, st_d, st_rst;
  logic [CNT_W-1:0] m1, m2, even_n, src;
  logic rise, ld, sq, upd;

  ptmr_step u_step (.value(st_q.cnt), .bcd(st_q.bcd), .minus1(m1), .minus2(m2));

  assign even_n = {st_q.reload[CNT_W-1:1], 1'b0};
  assign rise   = gate & ~st_q.gate_q;
  assign ld     = st_q.load | rise;
  assign sq     = st_q.mode[1];
  assign upd    = tick | cfg_we | data_we | rd_en | (gate ^ st_q.gate_q);

  always_comb begin
    st_rst = '0;
    st_rst.out = 1'b1;
  end

  always_comb begin
    st_d = st_q;
    st_d.gate_q = gate;
    if (st_q.armed) begin
      if (st_q.mode == MD_PULSE1) begin
        if (tick && st_q.trig) begin
          st_d.cnt  = st_q.reload;
          st_d.out  = 1'b0;
          st_d.run  = 1'b1;
          st_d.trig = rise;
        end else begin
          if (rise) st_d.trig = 1'b1;
          if (tick && st_q.run) begin
            st_d.cnt = m1;
            if (m1 == '0) begin
              st_d.out = 1'b1;
              st_d.run = 1'b0;
            end
          end
        end
      end else if (!gate) begin
        st_d.out  = 1'b1;
        st_d.load = ld;
      end else if (tick) begin
        st_d.load = 1'b0;
        if (ld) begin
          st_d.cnt   = sq ? even_n : st_q.reload;
          st_d.out   = 1'b1;
          st_d.extra = sq & st_q.reload[0];
        end else if (!sq) begin
          if (st_q.cnt == CNT_W'(1)) begin
            st_d.cnt = st_q.reload;
            st_d.out = 1'b1;
          end else begin
            st_d.cnt = m1;
            st_d.out = (m1 != CNT_W'(1));
          end
        end else if (st_q.cnt == CNT_W'(2)) begin
          if (st_q.extra) begin
            st_d.extra = 1'b0;
          end else begin
            st_d.out   = ~st_q.out;
            st_d.cnt   = even_n;
            st_d.extra = st_q.reload[0] & ~st_q.out;
          end
        end else begin
          st_d.cnt = m2;
        end
      end else begin
        st_d.load = ld;
      end
    end
    // host side
    if (cfg_we) begin
      if (cfg_snap) begin
        if (!st_q.held) begin
          st_d.held  = 1'b1;
          st_d.snap  = st_q.cnt;
          st_d.rd_hi = 1'b0;
        end
      end else begin
        st_d.mode  = cfg_mode;
        st_d.bcd   = cfg_bcd;
        st_d.wr_hi = 1'b0;
        st_d.rd_hi = 1'b0;
        st_d.held  = 1'b0;
        st_d.armed = 1'b0;
        st_d.out   = 1'b1;
        st_d.run   = 1'b0;
        st_d.trig  = 1'b0;
        st_d.load  = 1'b0;
        st_d.extra = 1'b0;
      end
    end
    if (data_we) begin
      if (!st_q.wr_hi) begin
        st_d.lo    = wdata;
        st_d.wr_hi = 1'b1;
      end else begin
        st_d.reload = {wdata, st_q.lo};
        st_d.wr_hi  = 1'b0;
        st_d.armed  = 1'b1;
        st_d.load   = 1'b1;
      end
    end
    if (rd_en) begin
      st_d.rd_hi = ~st_q.rd_hi;
      if (st_q.rd_hi) st_d.held = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= st_rst;
    else if (upd) st_q <= st_d;
  end

  assign src     = st_q.held ? st_q.snap : st_q.cnt;
  assign rd_byte = st_q.rd_hi ? src[15:8] : src[7:0];
  assign out_o   = st_q.out;
endmodule

// File: rtl/ptmr_triple.sv
module ptmr_triple
  import ptmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NUM_CH-1:0] tick,
  input  logic [NUM_CH-1:0] gate,
  output logic [NUM_CH-1:0] out
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic       ctrl_wr;
  logic [7:0] rbyte [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign ctrl_wr = wr_en && (addr == CTRL_ADDR) && (wdata[4:3] == 2'b00);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ptmr_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .tick    (tick[i]),
      .gate    (gate[i]),
      .cfg_we  (ctrl_wr && (wdata[7:6] == 2'(i))),
      .cfg_snap(wdata[5]),
      .cfg_mode(wdata[2:1]),
      .cfg_bcd (wdata[0]),
      .data_we (wr_en && (addr == ADDR_W'(i))),
      .wdata   (wdata),
      .rd_en   (rd_en && (addr == ADDR_W'(i))),
      .rd_byte (rbyte[i]),
      .out_o   (out[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = rbyte[i];
    end
  end
endmodule

// File: rtl/ptmr_triple_chk.sv
module ptmr_triple_chk #(
  parameter int NUM_CH = 3,
  localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:1]        cw,
  input logic [7:0]        rdata,
  input logic [NUM_CH-1:0] tick,
  input logic [NUM_CH-1:0] gate,
  input logic [NUM_CH-1:0] out
);
  logic [NUM_CH-1:0][1:0] sh_mode;
  logic [NUM_CH-1:0]      mode_hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign mode_hit[i] = wr_en && (addr == ADDR_W'(NUM_CH)) && !cw[5] &&
                         (cw[4:3] == 2'b00) && (cw[7:6] == 2'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sh_mode[i] <= 2'b00;
      else if (mode_hit[i]) sh_mode[i] <= cw[2:1];
    end

    p_mode_write_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mode_hit[i] |=> out[i]);
    p_gate_low_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_mode[i] != 2'b00 && !gate[i]) |=> out[i]);
    p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick[i] && gate[i] && !mode_hit[i]) |=> $stable(out[i]));
    p_single_low_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_mode[i] == 2'b01 && !out[i] && tick[i] && gate[i]) |=> out[i]);
  end

  p_reset_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&out));
  p_ctrl_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(NUM_CH)) |-> (rdata == 8'h00));
endmodule

bind ptmr_triple ptmr_triple_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .cw(wdata[7:1]), .rdata(rdata), .tick(tick), .gate(gate), .out(out)
);

// File: tb/ptmr_triple_test.sv
`timescale 1ns/1ps
module ptmr_triple_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic [2:0] tick, gate, out;

  typedef struct { int exp; string req; } exp_t;
  exp_t sbq[$];
  event mon_ev;
  int   act_val;
  int   n_cmp = 0;
  int   n_bad = 0;

  always #10 clk = ~clk;

  ptmr_triple uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick),
                   .gate(gate), .out(out));

  // monitor: pops the oldest expectation and compares
  initial forever begin
    @(mon_ev);
    if (sbq.size() == 0) begin
      n_bad++;
      $display("FAIL scoreboard empty: actual %0h", act_val);
    end else begin
      exp_t e;
      e = sbq.pop_front();
      n_cmp++;
      if (act_val != e.exp) begin
        n_bad++;
        $display("FAIL %s: actual %0h expected %0h", e.req, act_val, e.exp);
      end
    end
  end

  task automatic expect_val(string req, int actual, int expected);
    sbq.push_back('{expected, req});
    act_val = actual;
    -> mon_ev;
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m, input logic dec);
    wr(2'd3, {2'(ch), 1'b0, 2'b00, m, dec});
  endtask

  task automatic snap(input int ch);
    wr(2'd3, {2'(ch), 1'b1, 5'b00000});
  endtask

  task automatic load(input int ch, input logic [15:0] n);
    wr(2'(ch), n[7:0]);
    wr(2'(ch), n[15:8]);
  endtask

  task automatic rd_chk(input int ch, input int exp, input string req);
    logic [7:0] b;
    @(negedge clk); rd_en = 1'b1; addr = 2'(ch);
    #1 b = rdata;
    @(negedge clk); rd_en = 1'b0;
    expect_val(req, int'(b), exp);
  endtask

  task automatic tick_chk(input int ch, input int exp, input string req);
    @(negedge clk); tick[ch] = 1'b1;
    @(negedge clk); tick[ch] = 1'b0;
    expect_val(req, int'(out[ch]), exp);
  endtask

  task automatic set_gate(input int ch, input logic v);
    @(negedge clk); gate[ch] = v;
  endtask

  task automatic finish_run;
    #5;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    tick = '0; gate = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_val("R1", int'(out), 7);
    rd_chk(0, 8'h00, "R1");
    rd_chk(0, 8'h00, "R1");

    // R2 half-written count does not start the channel
    set_mode(0, 2'b01, 1'b0);
    wr(2'd0, 8'h03);
    for (int k = 0; k < 3; k++) tick_chk(0, 1, "R2");
    rd_chk(0, 8'h00, "R2");
    rd_chk(0, 8'h00, "R2");
    wr(2'd0, 8'h00);

    // R3 periodic pulse, N=3
    for (int k = 0; k < 9; k++) tick_chk(0, (k % 3 == 2) ? 0 : 1, "R3");
    tick_chk(0, 1, "R3");
    // R9 live read: count is 3
    rd_chk(0, 8'h03, "R9");
    rd_chk(0, 8'h00, "R9");

    // R6 gate low holds count, rising edge reloads
    set_gate(0, 1'b0);
    tick_chk(0, 1, "R6");
    tick_chk(0, 1, "R6");
    rd_chk(0, 8'h03, "R6");
    rd_chk(0, 8'h00, "R6");
    set_gate(0, 1'b1);
    tick_chk(0, 1, "R6");
    tick_chk(0, 1, "R6");
    tick_chk(0, 0, "R6");

    // R10 mode write stops channel and raises output
    set_mode(0, 2'b01, 1'b0);
    expect_val("R10", int'(out[0]), 1);
    tick_chk(0, 1, "R10");
    tick_chk(0, 1, "R10");
    rd_chk(0, 8'h01, "R10");
    rd_chk(0, 8'h00, "R10");

    // R4 square wave, N=5: 3 high, 2 low
    set_mode(1, 2'b10, 1'b0);
    load(1, 16'd5);
    for (int k = 0; k < 10; k++) tick_chk(1, (k % 5 < 3) ? 1 : 0, "R4");
    // R11 channel 0 untouched
    rd_chk(0, 8'h01, "R11");
    rd_chk(0, 8'h00, "R11");
    expect_val("R11", int'(out[0]), 1);

    // R5 single pulse, N=4
    set_mode(2, 2'b00, 1'b0);
    load(2, 16'd4);
    tick_chk(2, 1, "R5");
    tick_chk(2, 1, "R5");
    set_gate(2, 1'b0);
    set_gate(2, 1'b1);
    for (int k = 0; k < 4; k++) tick_chk(2, 0, "R5");
    tick_chk(2, 1, "R5");
    tick_chk(2, 1, "R5");
    set_gate(2, 1'b0);
    set_gate(2, 1'b1);
    tick_chk(2, 0, "R5");
    tick_chk(2, 0, "R5");
    set_gate(2, 1'b0);
    set_gate(2, 1'b1);
    for (int k = 0; k < 4; k++) tick_chk(2, 0, "R5");
    tick_chk(2, 1, "R5");

    // R7 decimal zero load wraps to 9999
    set_mode(1, 2'b01, 1'b1);
    load(1, 16'h0000);
    tick_chk(1, 1, "R7");
    tick_chk(1, 1, "R7");
    rd_chk(1, 8'h99, "R7");
    rd_chk(1, 8'h99, "R7");
    tick_chk(1, 1, "R7");
    rd_chk(1, 8'h98, "R7");
    rd_chk(1, 8'h99, "R7");
    // R7 digit borrow 1000 -> 0999
    set_mode(1, 2'b01, 1'b1);
    load(1, 16'h1000);
    tick_chk(1, 1, "R7");
    tick_chk(1, 1, "R7");
    rd_chk(1, 8'h99, "R7");
    rd_chk(1, 8'h09, "R7");

    // R8 snapshot held across reads, second command ignored
    snap(1);
    tick_chk(1, 1, "R8");
    tick_chk(1, 1, "R8");
    snap(1);
    rd_chk(1, 8'h99, "R8");
    tick_chk(1, 1, "R8");
    rd_chk(1, 8'h09, "R8");
    rd_chk(1, 8'h96, "R8");
    rd_chk(1, 8'h09, "R8");

    // R7 binary zero load wraps to FFFF
    set_mode(2, 2'b01, 1'b0);
    load(2, 16'h0000);
    tick_chk(2, 1, "R7");
    tick_chk(2, 1, "R7");
    rd_chk(2, 8'hFF, "R7");
    rd_chk(2, 8'hFF, "R7");

    // R10 channel 3 and reserved-bit words ignored; control address reads 0
    wr(2'd3, 8'hC2);
    wr(2'd3, 8'h48);
    rd_chk(1, 8'h96, "R10");
    rd_chk(1, 8'h09, "R10");
    tick_chk(1, 1, "R10");
    rd_chk(1, 8'h95, "R10");
    rd_chk(1, 8'h09, "R10");
    rd_chk(3, 8'h00, "R10");

    finish_run();
  end
endmodule